// File: doc/BRIEF.md
# Time-slot channel mapper

This block sits on the receive side of one channelised serial link. It runs in either a 24-slot frame mode or a 32-slot frame mode. Each link bit clock carries one received bit. A frame-start pulse marks where each frame begins. A programmable slot table gives each time-slot one of two settings: assigned to a 7-bit channel number, or unassigned. A second table holds one rate flag per channel. A channel marked as reduced rate carries only seven payload bits per slot. Its other channels use all eight bits of a slot.

For every received bit, the mapper delivers the same bit one clock later. With it come the owning channel number, a valid strobe and a slot-end flag. The slot-end flag marks the final bit of each assigned slot, so downstream octet packers for transparent channels stay aligned to slot boundaries. A channel can own any set of slots, and those slots need not be adjacent. Both tables are double-buffered. Writes land in a shadow copy, and the whole shadow copy becomes active at the next frame-start pulse, so no frame is ever mapped with a mix of old and new entries.

The sequencer has three states. HUNT is entered at reset and lasts until the first frame-start pulse. FRAMING marks the one overhead bit that opens a 24-slot frame when the link runs freely. PAYLOAD covers the slot bits. The transitions are:
- HUNT→PAYLOAD on a frame-start pulse.
- PAYLOAD→PAYLOAD bit by bit, and slot by slot.
- PAYLOAD→FRAMING after slot 23, bit 7, in 24-slot mode.
- PAYLOAD→PAYLOAD with a wrap to slot 0 after slot 31, bit 7, in 32-slot mode.
- FRAMING→PAYLOAD after one bit.
- Any state→PAYLOAD on a frame-start pulse.

Top module: `tsm_slot_mapper`

## Requirements
- R1: After reset and until the first `frame_sync`, `out_valid` and `out_slot_end` stay 0 and `out_chan` stays 0.
- R2: The bit presented with `frame_sync` high is the first bit of a frame. In 24-slot mode (`mode_e1`=0), that bit is the framing bit, and the next 192 bits are slots 0..23 with bit index 0..7 each. In 32-slot mode (`mode_e1`=1), that bit is slot 0 bit 0, and slots 0..31 follow in order. A pulse arriving early restarts the count.
- R3: In 24-slot mode the framing bit never raises `out_valid` or `out_slot_end`.
- R4: In 32-slot mode slot 0 is treated as unassigned, whatever its table entry holds.
- R5: `out_bit` equals `rx_bit` from one clock earlier. All outputs are registered with the same one-clock delay.
- R6: A bit in an unassigned slot gives `out_valid`=0, `out_slot_end`=0 and `out_chan`=0.
- R7: In a slot assigned to a full-rate channel (rate flag 0), all 8 bits give `out_valid`=1 with `out_chan` equal to the entry's channel. A channel may own any non-adjacent set of slots.
- R8: In a slot assigned to a reduced-rate channel (rate flag 1), bits 0..6 are valid and bit 7 gives `out_valid`=0.
- R9: `out_slot_end` is 1 exactly on bit 7 of an assigned payload slot, at either rate.
- R10: Slot and rate table writes change the shadow copy only. The active copy takes the whole shadow copy at the next `frame_sync`. A write made in the same cycle as `frame_sync` becomes active at the following pulse.
- R11: Without new pulses the link keeps running freely. In 24-slot mode, slot 23 bit 7 is followed by a framing bit. In 32-slot mode, slot 31 bit 7 is followed by slot 0 bit 0.
- R12: After reset every slot entry is unassigned and every channel is full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e1 | input | 1 | 0: 24 slots plus framing bit; 1: 32 slots with slot 0 reserved |
| frame_sync | input | 1 | High with the first bit of a frame |
| rx_bit | input | 1 | Serial receive data |
| slot_we | input | 1 | Write strobe for the slot table shadow |
| slot_addr | input | 5 | Slot index to write |
| slot_used | input | 1 | 1: slot assigned; 0: unassigned |
| slot_chan | input | 7 | Channel number for the slot |
| rate_we | input | 1 | Write strobe for the rate table shadow |
| rate_chan | input | 7 | Channel whose rate flag is written |
| rate_56k | input | 1 | 1: reduced rate (7 bits per slot); 0: full rate |
| out_bit | output | 1 | Delayed data bit |
| out_valid | output | 1 | Bit belongs to `out_chan` payload |
| out_chan | output | 7 | Owning channel; 0 outside assigned slots |
| out_slot_end | output | 1 | Last bit of an assigned slot |

## Verification
The mapping is driven with pseudo-random data through table layouts of four kinds:
- Channels spread over non-adjacent slots, including a channel numbered 0 and the highest channel number. This separates a correct lookup from one that confuses "assigned" with "channel non-zero".
- A reduced-rate channel sharing the frame with full-rate ones. This shows whether bit 7 is dropped per channel rather than per link.
- Runs in 32-slot mode with slot 0 deliberately assigned. These expose a missing reserved-slot guard.
- Free-running multi-frame stretches, early pulses, and table writes both mid-frame and in the pulse cycle. These separate correct wrap and framing-bit placement from a counter that only works when pulses arrive, and separate correct double-buffering from tables that update immediately or one frame late.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
    localparam int CH_W        = 7;
    localparam int SLOT_W      = 5;
    localparam int SLOTS       = 1 << SLOT_W;
    localparam int CHANS       = 1 << CH_W;
    localparam int SLOT_BITS   = 8;
    localparam int BIT_W       = $clog2(SLOT_BITS);
    localparam int T1_SLOTS    = 24;
    localparam int ENTRY_W     = CH_W + 1;

    localparam logic [SLOT_W-1:0] T1_LAST  = SLOT_W'(T1_SLOTS - 1);
    localparam logic [SLOT_W-1:0] E1_LAST  = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(SLOT_BITS - 1);

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_FRAMING = 2'd1,
        ST_PAYLOAD = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            used;
        logic [CH_W-1:0] chan;
    } slot_entry_t;
endpackage

// File: rtl/tsm_shadow_table.sv
module tsm_shadow_table #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] shadow_q [DEPTH];
    logic [W-1:0] active_q [DEPTH];

    // Shadow takes writes; active copies the whole shadow on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
        end else begin
            if (commit) begin
                for (int i = 0; i < DEPTH; i++) begin
                    active_q[i] <= shadow_q[i];
                end
            end
            if (wr_en) begin
                shadow_q[wr_addr] <= wr_data;
            end
        end
    end

    assign rd_data = active_q[rd_addr];
endmodule

// File: rtl/tsm_frame_seq.sv
module tsm_frame_seq
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_e1,
    input  logic              frame_sync,
    output logic              cur_live,
    output logic              cur_fbit,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit
);
    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot = mode_e1 ? E1_LAST : T1_LAST;

    // State register: holds the position of the next bit to arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            slot_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
        end
    end

    // Next-position logic.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        bit_d   = bit_q;
        if (frame_sync) begin
            state_d = ST_PAYLOAD;
            slot_d  = '0;
            bit_d   = mode_e1 ? BIT_W'(1) : '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    state_d = ST_HUNT;
                end
                ST_FRAMING: begin
                    state_d = ST_PAYLOAD;
                    slot_d  = '0;
                    bit_d   = '0;
                end
                ST_PAYLOAD: begin
                    if (bit_q != BIT_LAST) begin
                        bit_d = bit_q + BIT_W'(1);
                    end else begin
                        bit_d = '0;
                        if (slot_q == last_slot) begin
                            slot_d  = '0;
                            state_d = mode_e1 ? ST_PAYLOAD : ST_FRAMING;
                        end else begin
                            slot_d = slot_q + SLOT_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                end
            endcase
        end
    end

    // Output logic: classify the bit present on the input this cycle.
    always_comb begin
        cur_live = frame_sync || (state_q != ST_HUNT);
        cur_fbit = frame_sync ? !mode_e1 : (state_q == ST_FRAMING);
        cur_slot = frame_sync ? '0 : slot_q;
        cur_bit  = frame_sync ? '0 : bit_q;
    end
endmodule

// File: rtl/tsm_slot_mapper.sv
module tsm_slot_mapper
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_e1,
    input  logic              frame_sync,
    input  logic              rx_bit,
    input  logic              slot_we,
    input  logic [SLOT_W-1:0] slot_addr,
    input  logic              slot_used,
    input  logic [CH_W-1:0]   slot_chan,
    input  logic              rate_we,
    input  logic [CH_W-1:0]   rate_chan,
    input  logic              rate_56k,
    output logic              out_bit,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_slot_end
);
    logic              cur_live;
    logic              cur_fbit;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;
    slot_entry_t       entry;
    logic              chan_56k;
    logic              in_slot;
    logic              keep_bit;

    tsm_frame_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_e1    (mode_e1),
        .frame_sync (frame_sync),
        .cur_live   (cur_live),
        .cur_fbit   (cur_fbit),
        .cur_slot   (cur_slot),
        .cur_bit    (cur_bit)
    );

    tsm_shadow_table #(.DEPTH(SLOTS), .W(ENTRY_W)) slot_tab_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_we),
        .wr_addr (slot_addr),
        .wr_data ({slot_used, slot_chan}),
        .commit  (frame_sync),
        .rd_addr (cur_slot),
        .rd_data (entry)
    );

    tsm_shadow_table #(.DEPTH(CHANS), .W(1)) rate_tab_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rate_we),
        .wr_addr (rate_chan),
        .wr_data (rate_56k),
        .commit  (frame_sync),
        .rd_addr (entry.chan),
        .rd_data (chan_56k)
    );

    always_comb begin
        in_slot  = cur_live && !cur_fbit && entry.used
                   && !(mode_e1 && (cur_slot == '0));
        keep_bit = !(chan_56k && (cur_bit == BIT_LAST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit      <= 1'b0;
            out_valid    <= 1'b0;
            out_chan     <= '0;
            out_slot_end <= 1'b0;
        end else begin
            out_bit      <= rx_bit;
            out_valid    <= in_slot && keep_bit;
            out_chan     <= in_slot ? entry.chan : '0;
            out_slot_end <= in_slot && (cur_bit == BIT_LAST);
        end
    end
endmodule

// File: rtl/tsm_slot_mapper_chk.sv
module tsm_slot_mapper_chk
    import tsm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_e1,
    input logic              frame_sync,
    input logic              out_valid,
    input logic              out_slot_end,
    input logic              cur_live,
    input logic              cur_fbit,
    input logic [SLOT_W-1:0] cur_slot,
    input logic [BIT_W-1:0]  cur_bit
);
    a_r1_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_live |=> (!out_valid && !out_slot_end));

    a_r3_fbit_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cur_fbit |=> (!out_valid && !out_slot_end));

    a_r4_e1_slot0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_live && mode_e1 && !cur_fbit && cur_slot == '0) |=> !out_valid);

    a_r2_sync_origin: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (frame_sync || (!cur_fbit && cur_slot == '0 &&
                        cur_bit == ($past(mode_e1) ? BIT_W'(1) : BIT_W'(0)))));

    a_r11_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_live && !frame_sync && !cur_fbit) |->
            (cur_slot <= (mode_e1 ? E1_LAST : T1_LAST)));

    a_r9_slot_end_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_slot_end |=> !out_slot_end);
endmodule

bind tsm_slot_mapper tsm_slot_mapper_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_e1      (mode_e1),
    .frame_sync   (frame_sync),
    .out_valid    (out_valid),
    .out_slot_end (out_slot_end),
    .cur_live     (cur_live),
    .cur_fbit     (cur_fbit),
    .cur_slot     (cur_slot),
    .cur_bit      (cur_bit)
);

// File: tb/tsm_slot_mapper_tb_top.sv
module tsm_slot_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_e1 = 1'b0;
    logic       frame_sync = 1'b0;
    logic       rx_bit = 1'b0;
    logic       slot_we = 1'b0;
    logic [4:0] slot_addr = '0;
    logic       slot_used = 1'b0;
    logic [6:0] slot_chan = '0;
    logic       rate_we = 1'b0;
    logic [6:0] rate_chan = '0;
    logic       rate_56k = 1'b0;
    logic       out_bit;
    logic       out_valid;
    logic [6:0] out_chan;
    logic       out_slot_end;

    always #2 clk = ~clk;

    tsm_slot_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .frame_sync(frame_sync),
        .rx_bit(rx_bit), .slot_we(slot_we), .slot_addr(slot_addr),
        .slot_used(slot_used), .slot_chan(slot_chan), .rate_we(rate_we),
        .rate_chan(rate_chan), .rate_56k(rate_56k), .out_bit(out_bit),
        .out_valid(out_valid), .out_chan(out_chan), .out_slot_end(out_slot_end)
    );

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements
    bit       sh_used [32];
    bit [6:0] sh_chan [32];
    bit       sh_56   [128];
    bit       ac_used [32];
    bit [6:0] ac_chan [32];
    bit       ac_56   [128];
    int       m_state = 0;  // 0 hunt, 1 framing, 2 payload
    int       m_slot = 0;
    int       m_bit = 0;
    bit       drv_e1 = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    bit       p_swe = 1'b0;
    bit [4:0] p_sa;
    bit       p_su;
    bit [6:0] p_sc;
    bit       p_rwe = 1'b0;
    bit [6:0] p_rc;
    bit       p_r56;

    task automatic step(input bit sync, input string scen);
        bit live, fbit, inslot, ev, ee, eb;
        bit [6:0] ec;
        int slot, bn, last;
        string tag;
        @(negedge clk);
        frame_sync = sync;
        mode_e1    = drv_e1;
        rx_bit     = lfsr[0];
        eb         = lfsr[0];
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        slot_we = p_swe; slot_addr = p_sa; slot_used = p_su; slot_chan = p_sc;
        rate_we = p_rwe; rate_chan = p_rc; rate_56k = p_r56;
        live = 1'b1; fbit = 1'b0; slot = 0; bn = 0;
        last = drv_e1 ? 31 : 23;
        if (sync) begin
            fbit = !drv_e1;
            m_state = 2; m_slot = 0; m_bit = drv_e1 ? 1 : 0;
        end else if (m_state == 0) begin
            live = 1'b0;
        end else if (m_state == 1) begin
            fbit = 1'b1;
            m_state = 2; m_slot = 0; m_bit = 0;
        end else begin
            slot = m_slot; bn = m_bit;
            if (m_bit != 7) m_bit++;
            else begin
                m_bit = 0;
                if (m_slot == last) begin
                    m_slot = 0;
                    m_state = drv_e1 ? 2 : 1;
                end else m_slot++;
            end
        end
        inslot = live && !fbit && !(drv_e1 && slot == 0) && ac_used[slot];
        ec = inslot ? ac_chan[slot] : 7'd0;
        ev = inslot && !(ac_56[ac_chan[slot]] && bn == 7);
        ee = inslot && bn == 7;
        if (!live) tag = "R1";
        else if (fbit) tag = "R3";
        else if (drv_e1 && slot == 0) tag = "R4";
        else if (!ac_used[slot]) tag = "R6";
        else if (ac_56[ac_chan[slot]] && bn == 7) tag = "R8";
        else tag = "R7";
        // R10 model: commit old shadow first, then apply this cycle's write
        if (sync) begin
            ac_used = sh_used; ac_chan = sh_chan; ac_56 = sh_56;
        end
        if (p_swe) begin sh_used[p_sa] = p_su; sh_chan[p_sa] = p_sc; end
        if (p_rwe) sh_56[p_rc] = p_r56;
        p_swe = 1'b0; p_rwe = 1'b0;
        @(posedge clk);
        #1;
        checks++;
        if (out_bit !== eb) tag = "R5";
        else if (out_slot_end !== ee) tag = "R9";
        if (out_valid !== ev || out_chan !== ec || out_slot_end !== ee || out_bit !== eb) begin
            errors++;
            $display("FAIL %s/%s slot=%0d bit=%0d actual v=%b ch=%0d end=%b d=%b expected v=%b ch=%0d end=%b d=%b",
                     tag, scen, slot, bn, out_valid, out_chan, out_slot_end, out_bit, ev, ec, ee, eb);
        end
    endtask

    task automatic run_bits(input int n, input string scen);
        for (int i = 0; i < n; i++) step(1'b0, scen);
    endtask

    task automatic wr_slot(input int a, input bit u, input int c, input bit sync, input string scen);
        p_swe = 1'b1; p_sa = 5'(a); p_su = u; p_sc = 7'(c);
        step(sync, scen);
    endtask

    task automatic wr_rate(input int c, input bit r, input string scen);
        p_rwe = 1'b1; p_rc = 7'(c); p_r56 = r;
        step(1'b0, scen);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_slot_end !== 1'b0 || out_chan !== 7'd0) begin
            errors++;
            $display("FAIL R1 reset actual v=%b end=%b ch=%0d expected v=0 end=0 ch=0",
                     out_valid, out_slot_end, out_chan);
        end
        rst_n = 1'b1;
        run_bits(20, "R1");
        // R12: untouched tables map nothing
        drv_e1 = 1'b0;
        step(1'b1, "R12");
        run_bits(192, "R12");
    endtask

    task automatic t_t1_map();
        wr_slot(0, 1, 5, 0, "R7");
        wr_slot(3, 1, 5, 0, "R7");
        wr_slot(17, 1, 5, 0, "R7");
        wr_slot(23, 1, 127, 0, "R7");
        wr_slot(10, 1, 0, 0, "R7");
        wr_slot(1, 1, 9, 0, "R8");
        wr_slot(2, 1, 9, 0, "R8");
        wr_rate(9, 1, "R8");
        run_bits(192 - 8, "R7");
        step(1'b1, "R2");
        run_bits(192, "R7");
        step(1'b1, "R2");
        run_bits(192, "R9");
    endtask

    task automatic t_e1_map();
        drv_e1 = 1'b1;
        step(1'b1, "R2");
        wr_slot(0, 1, 3, 0, "R4");
        wr_slot(31, 1, 3, 0, "R7");
        wr_slot(16, 1, 40, 0, "R8");
        wr_rate(40, 1, "R8");
        wr_slot(5, 1, 9, 0, "R8");
        wr_slot(3, 0, 0, 0, "R6");
        run_bits(255 - 6, "R4");
        step(1'b1, "R2");
        run_bits(255, "R4");
    endtask

    task automatic t_shadow();
        step(1'b1, "R10");
        run_bits(40, "R10");
        wr_slot(20, 1, 77, 0, "R10");
        wr_rate(5, 1, "R10");
        run_bits(255 - 42, "R10");
        wr_slot(21, 1, 78, 1, "R10");
        run_bits(255, "R10");
        step(1'b1, "R10");
        run_bits(255, "R10");
    endtask

    task automatic t_wrap();
        drv_e1 = 1'b1;
        step(1'b1, "R11");
        run_bits(2 * 256 + 40, "R11");
        drv_e1 = 1'b0;
        step(1'b1, "R11");
        run_bits(3 * 193 + 20, "R11");
    endtask

    task automatic t_resync();
        drv_e1 = 1'b1;
        step(1'b1, "R2");
        run_bits(70, "R2");
        step(1'b1, "R2");
        run_bits(300, "R2");
        drv_e1 = 1'b0;
        step(1'b1, "R2");
        run_bits(100, "R2");
        step(1'b1, "R2");
        run_bits(200, "R2");
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_t1_map();
        t_e1_map();
        t_shadow();
        t_wrap();
        t_resync();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule